// File: doc/BRIEF.md
# Dual 16-Pin GPIO Port Controller

This block holds two general-purpose ports of sixteen pins each, named A and B, behind a small register bus. Each port has a control word and a data register. The control word carries two bits per pin: one selects output drive and one enables a pull-up. A peripheral side can also drive the same pins through its own direction and level vectors. These vectors are latched by a load strobe.

The level of every line is resolved from three sources at once: the CPU drive, the peripheral drive and the pull-up. When the CPU writes a port's control or data register, the block compares the lines before and after the write. Each change is offered to up to four enabled clients. Each client has a trigger mask for port A and one for port B. A client whose mask overlaps the changed bits gets a one-cycle notify pulse. The current line values of both ports are always visible on the outputs.

A pin-interrupt control register exists only so that an attempt to enable pin interrupts can be caught. Any nonzero value written there raises a configuration-error flag.

Top module: `gpio_dual_port`

## Requirements
- R1: In a port's 32-bit control word, bit 2n makes pin n a CPU-driven output and bit 2n+1 enables the pull-up on pin n.
- R2: Each line resolves to (cpu_dir & cpu_data) | (per_dir & per_level) | (~(cpu_dir | per_dir) & pull). When both sides drive a pin, a 1 from either side wins. A driven pin ignores its pull-up.
- R3: A pin driven by neither side and without a pull-up reads 0.
- R4: Word addresses are: 0 control A, 1 data A, 2 control B, 3 data B, 4 pin-interrupt control. Any other address reads 0. A read returns its value one cycle after the read strobe. A control read returns the stored word. A data read returns the resolved lines, not the value last written.
- R5: A CPU write to a port's control or data register compares the lines before the write with the lines after it, using XOR. When the result is nonzero, notify pulses for exactly one cycle, starting one cycle after the write edge.
- R6: A client's notify bit rises only if its enable bit is set and its trigger mask for the written port overlaps the change vector. Trigger masks for client i sit at bits [16i+15:16i].
- R7: A register write that leaves the lines of the written port unchanged produces no notify pulse.
- R8: A per_we strobe latches the peripheral direction and level vectors for both ports. The resolved lines reflect them from the following cycle.
- R9: Writing a nonzero value to the pin-interrupt control register sets unsup_cfg. Writing zero clears it. The stored value reads back.
- R10: After reset all registers are 0, so all pins are inputs with pull-ups off. Lines, notify, unsup_cfg and read data are all 0.
- R11: A peripheral load alone never produces a notify pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| per_we | input | 1 | Peripheral vector load strobe |
| per_dir_a | input | 16 | Peripheral drive enables, port A |
| per_lvl_a | input | 16 | Peripheral drive levels, port A |
| per_dir_b | input | 16 | Peripheral drive enables, port B |
| per_lvl_b | input | 16 | Peripheral drive levels, port B |
| client_en | input | 4 | Client enable, one bit per client |
| trig_mask_a | input | 64 | Port A trigger masks, 16 bits per client |
| trig_mask_b | input | 64 | Port B trigger masks, 16 bits per client |
| line_a | output | 16 | Resolved port A lines |
| line_b | output | 16 | Resolved port B lines |
| notify | output | 4 | One-cycle change pulse, one bit per client |
| unsup_cfg | output | 1 | Nonzero pin-interrupt control written |

## Verification
The resolver is driven through a vector table, and each row isolates one case:
- pins left floating;
- pull-up only;
- CPU drive only;
- a split between CPU and peripheral drive;
- peripheral drive beside pull-ups;
- both sides driving at once, which shows OR resolution;
- all control bits set, which shows that a pull-up is ignored on a driven pin.

The notification tests are split so that each one can fail on its own:
- a change seen only by a port A mask;
- a change seen only by a port B mask;
- a control write that changes two pins and reaches two clients;
- a repeated identical write;
- a write of data to input-only pins;
- a peripheral-only load;
- a disabled client whose mask overlaps everything.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GP_PINS    = 16;
  localparam int GP_CLIENTS = 4;
  localparam int GP_ADDR_W  = 3;
  localparam int GP_BUS_W   = 32;

  localparam int ADR_CTRL_A = 0;
  localparam int ADR_DATA_A = 1;
  localparam int ADR_CTRL_B = 2;
  localparam int ADR_DATA_B = 3;
  localparam int ADR_INTCTL = 4;
endpackage

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int PINS = gpio_pkg::GP_PINS,
  localparam int CW  = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            data_we,
  input  logic [CW-1:0]   wdata,
  input  logic            per_we,
  input  logic [PINS-1:0] per_dir_in,
  input  logic [PINS-1:0] per_lvl_in,
  output logic [CW-1:0]   ctrl_q,
  output logic [PINS-1:0] lines,
  output logic            chg_pend,
  output logic [PINS-1:0] chg_vec
);
  // Direction bits sit on even positions of the control word.
  function automatic logic [PINS-1:0] f_dir(input logic [CW-1:0] c);
    logic [PINS-1:0] d;
    for (int i = 0; i < PINS; i++) d[i] = c[2*i];
    return d;
  endfunction

  // Pull-up enables sit on odd positions.
  function automatic logic [PINS-1:0] f_pull(input logic [CW-1:0] c);
    logic [PINS-1:0] p;
    for (int i = 0; i < PINS; i++) p[i] = c[2*i+1];
    return p;
  endfunction

  function automatic logic [PINS-1:0] f_resolve(
    input logic [PINS-1:0] cdir, input logic [PINS-1:0] cdat,
    input logic [PINS-1:0] pdir, input logic [PINS-1:0] pdat,
    input logic [PINS-1:0] pull);
    return (cdir & cdat) | (pdir & pdat) | (~(cdir | pdir) & pull);
  endfunction

  logic [PINS-1:0] data_q, per_dir_q, per_lvl_q, prev_q;
  logic            pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      per_dir_q <= '0;
      per_lvl_q <= '0;
      prev_q    <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (data_we) data_q <= wdata[PINS-1:0];
      if (per_we) begin
        per_dir_q <= per_dir_in;
        per_lvl_q <= per_lvl_in;
      end
      pend_q <= ctrl_we | data_we;
      if (ctrl_we | data_we) prev_q <= lines;
    end
  end

  always_comb begin
    lines    = f_resolve(f_dir(ctrl_q), data_q, per_dir_q, per_lvl_q, f_pull(ctrl_q));
    chg_pend = pend_q;
    chg_vec  = pend_q ? (lines ^ prev_q) : '0;
  end
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify #(
  parameter int PINS    = gpio_pkg::GP_PINS,
  parameter int CLIENTS = gpio_pkg::GP_CLIENTS,
  localparam int MW     = PINS * CLIENTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CLIENTS-1:0] client_en,
  input  logic [MW-1:0]      mask_a,
  input  logic [MW-1:0]      mask_b,
  input  logic [PINS-1:0]    chg_a,
  input  logic [PINS-1:0]    chg_b,
  output logic [CLIENTS-1:0] notify_q
);
  logic [CLIENTS-1:0] hit;

  for (genvar i = 0; i < CLIENTS; i++) begin : g_client
    always_comb begin
      hit[i] = client_en[i] &
               ((|(mask_a[i*PINS +: PINS] & chg_a)) |
                (|(mask_b[i*PINS +: PINS] & chg_b)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) notify_q <= '0;
    else        notify_q <= hit;
  end
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int PINS    = gpio_pkg::GP_PINS,
  parameter int CLIENTS = gpio_pkg::GP_CLIENTS,
  parameter int ADDR_W  = gpio_pkg::GP_ADDR_W,
  parameter int BUS_W   = gpio_pkg::GP_BUS_W,
  localparam int MW     = PINS * CLIENTS,
  localparam int CW     = 2 * PINS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               per_we,
  input  logic [PINS-1:0]    per_dir_a,
  input  logic [PINS-1:0]    per_lvl_a,
  input  logic [PINS-1:0]    per_dir_b,
  input  logic [PINS-1:0]    per_lvl_b,
  input  logic [CLIENTS-1:0] client_en,
  input  logic [MW-1:0]      trig_mask_a,
  input  logic [MW-1:0]      trig_mask_b,
  output logic [PINS-1:0]    line_a,
  output logic [PINS-1:0]    line_b,
  output logic [CLIENTS-1:0] notify,
  output logic               unsup_cfg
);
  import gpio_pkg::*;

  logic sel_ctrl_a, sel_data_a, sel_ctrl_b, sel_data_b, sel_intctl;
  logic [CW-1:0]   ctrl_a_q, ctrl_b_q;
  logic [PINS-1:0] intctl_q;

  // Named internal events for the checker.
  logic            ev_pend_a, ev_pend_b;
  logic [PINS-1:0] ev_chg_a, ev_chg_b;

  always_comb begin
    sel_ctrl_a = bus_addr == ADDR_W'(ADR_CTRL_A);
    sel_data_a = bus_addr == ADDR_W'(ADR_DATA_A);
    sel_ctrl_b = bus_addr == ADDR_W'(ADR_CTRL_B);
    sel_data_b = bus_addr == ADDR_W'(ADR_DATA_B);
    sel_intctl = bus_addr == ADDR_W'(ADR_INTCTL);
  end

  gpio_port #(.PINS(PINS)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr & sel_ctrl_a), .data_we(bus_wr & sel_data_a),
    .wdata(bus_wdata[CW-1:0]),
    .per_we(per_we), .per_dir_in(per_dir_a), .per_lvl_in(per_lvl_a),
    .ctrl_q(ctrl_a_q), .lines(line_a),
    .chg_pend(ev_pend_a), .chg_vec(ev_chg_a)
  );

  gpio_port #(.PINS(PINS)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr & sel_ctrl_b), .data_we(bus_wr & sel_data_b),
    .wdata(bus_wdata[CW-1:0]),
    .per_we(per_we), .per_dir_in(per_dir_b), .per_lvl_in(per_lvl_b),
    .ctrl_q(ctrl_b_q), .lines(line_b),
    .chg_pend(ev_pend_b), .chg_vec(ev_chg_b)
  );

  gpio_notify #(.PINS(PINS), .CLIENTS(CLIENTS)) u_notify (
    .clk(clk), .rst_n(rst_n), .client_en(client_en),
    .mask_a(trig_mask_a), .mask_b(trig_mask_b),
    .chg_a(ev_chg_a), .chg_b(ev_chg_b),
    .notify_q(notify)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intctl_q  <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && sel_intctl) intctl_q <= bus_wdata[PINS-1:0];
      if (bus_rd) begin
        unique case (1'b1)
          sel_ctrl_a: bus_rdata <= BUS_W'(ctrl_a_q);
          sel_data_a: bus_rdata <= BUS_W'(line_a);
          sel_ctrl_b: bus_rdata <= BUS_W'(ctrl_b_q);
          sel_data_b: bus_rdata <= BUS_W'(line_b);
          sel_intctl: bus_rdata <= BUS_W'(intctl_q);
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  assign unsup_cfg = |intctl_q;
endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
  parameter int PINS    = gpio_pkg::GP_PINS,
  parameter int CLIENTS = gpio_pkg::GP_CLIENTS,
  parameter int ADDR_W  = gpio_pkg::GP_ADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [PINS-1:0]    wdata_lo,
  input logic               per_we,
  input logic [CLIENTS-1:0] client_en,
  input logic [CLIENTS-1:0] notify,
  input logic               unsup_cfg,
  input logic               ev_pend_a,
  input logic               ev_pend_b,
  input logic [PINS-1:0]    ev_chg_a,
  input logic [PINS-1:0]    ev_chg_b
);
  logic pend_any;
  assign pend_any = ev_pend_a | ev_pend_b;

  a_r5_notify_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (notify != '0) |-> $past(pend_any));

  a_r6_only_enabled_clients: assert property (@(posedge clk) disable iff (!rst_n)
    (notify & ~$past(client_en)) == '0);

  a_r7_quiet_on_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any && ev_chg_a == '0 && ev_chg_b == '0) |=> notify == '0);

  a_r9_flag_nonzero_intctl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(gpio_pkg::ADR_INTCTL) && wdata_lo != '0) |=> unsup_cfg);

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (notify == '0 && !unsup_cfg));

  a_r11_peripheral_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (per_we && !pend_any) |=> notify == '0);
endmodule

bind gpio_dual_port gpio_dual_port_chk #(.PINS(PINS), .CLIENTS(CLIENTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[PINS-1:0]), .per_we(per_we), .client_en(client_en),
  .notify(notify), .unsup_cfg(unsup_cfg),
  .ev_pend_a(ev_pend_a), .ev_pend_b(ev_pend_b),
  .ev_chg_a(ev_chg_a), .ev_chg_b(ev_chg_b)
);

// File: tb/gpio_dual_port_tb.sv
`timescale 1ns/1ps
module gpio_dual_port_tb;
  localparam int P = 16;
  localparam int C = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          per_we = 1'b0;
  logic [P-1:0]  per_dir_a = '0, per_lvl_a = '0, per_dir_b = '0, per_lvl_b = '0;
  logic [C-1:0]  client_en = '0;
  logic [P*C-1:0] trig_mask_a = '0, trig_mask_b = '0;
  logic [P-1:0]  line_a, line_b;
  logic [C-1:0]  notify;
  logic          unsup_cfg;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_dual_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_we(per_we), .per_dir_a(per_dir_a), .per_lvl_a(per_lvl_a),
    .per_dir_b(per_dir_b), .per_lvl_b(per_lvl_b),
    .client_en(client_en), .trig_mask_a(trig_mask_a), .trig_mask_b(trig_mask_b),
    .line_a(line_a), .line_b(line_b), .notify(notify), .unsup_cfg(unsup_cfg)
  );

  // Stimulus rows: control word, CPU data, peripheral dir, peripheral level.
  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] data;
    logic [15:0] pdir;
    logic [15:0] plvl;
  } row_t;

  localparam row_t TABLE [7] = '{
    '{32'h0000_0000, 16'hFFFF, 16'h0000, 16'h0000},  // R3 floating
    '{32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000},  // R1 pull only
    '{32'h5555_5555, 16'h1234, 16'h0000, 16'h0000},  // R1 CPU drive
    '{32'h0000_5555, 16'hFFAB, 16'hFF00, 16'h0F00},  // R2 split drive
    '{32'hAAAA_0000, 16'h0000, 16'h0F00, 16'h0000},  // R2 periph + pull
    '{32'h5555_5555, 16'h00F0, 16'h000F, 16'h000F},  // R2 both drive
    '{32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000}   // R2 pull ignored
  };

  // Per-pin model of the line rule, written as a priority of cases.
  function automatic logic [15:0] model(input row_t r);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      if (r.ctrl[2*i] && r.data[i])                       v[i] = 1'b1;
      else if (r.pdir[i] && r.plvl[i])                    v[i] = 1'b1;
      else if (!r.ctrl[2*i] && !r.pdir[i] && r.ctrl[2*i+1]) v[i] = 1'b1;
      else                                                v[i] = 1'b0;
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic per_load(input logic [15:0] da, input logic [15:0] la,
                          input logic [15:0] db, input logic [15:0] lb);
    @(negedge clk);
    per_we = 1'b1;
    per_dir_a = da; per_lvl_a = la; per_dir_b = db; per_lvl_b = lb;
    @(negedge clk);
    per_we = 1'b0;
  endtask

  // Write, then check the pulse in the following cycle and its end one cycle later.
  task automatic write_expect(input string tag, input logic [2:0] a,
                              input logic [31:0] d, input logic [3:0] exp);
    bus_write(a, d);
    @(negedge clk);
    check(tag, 32'(notify), 32'(exp));
    @(negedge clk);
    if (exp != 0) check({tag, " pulse end R5"}, 32'(notify), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    do_reset();
    // R10 reset state
    check("R10 line_a", 32'(line_a), 0);
    check("R10 line_b", 32'(line_b), 0);
    check("R10 notify", 32'(notify), 0);
    check("R10 unsup", 32'(unsup_cfg), 0);
    bus_read(3'd0, rd); check("R10 ctrl A read", rd, 0);
    bus_read(3'd3, rd); check("R10 data B read", rd, 0);

    // Table walk: R1 R2 R3 R4 R8
    foreach (TABLE[k]) begin
      bus_write(3'd0, TABLE[k].ctrl);
      bus_write(3'd1, 32'(TABLE[k].data));
      bus_write(3'd2, TABLE[k].ctrl);
      bus_write(3'd3, 32'(TABLE[k].data));
      per_load(TABLE[k].pdir, TABLE[k].plvl, TABLE[k].pdir, TABLE[k].plvl);
      check($sformatf("R2 line_a row %0d", k), 32'(line_a), 32'(model(TABLE[k])));
      bus_read(3'd1, rd);
      check($sformatf("R4 data A row %0d", k), rd, 32'(model(TABLE[k])));
      bus_read(3'd3, rd);
      check($sformatf("R4 data B row %0d", k), rd, 32'(model(TABLE[k])));
      bus_read(3'd2, rd);
      check($sformatf("R4 ctrl B row %0d", k), rd, TABLE[k].ctrl);
    end

    // Notification tests from a clean state.
    per_dir_a = '0; per_lvl_a = '0; per_dir_b = '0; per_lvl_b = '0;
    do_reset();
    client_en = 4'b0111;
    trig_mask_a[0*P +: P] = 16'h0001;
    trig_mask_a[1*P +: P] = 16'h0100;
    trig_mask_b[2*P +: P] = 16'h0001;
    trig_mask_a[3*P +: P] = 16'hFFFF;
    trig_mask_b[3*P +: P] = 16'hFFFF;

    write_expect("R7 ctrl A no change", 3'd0, 32'h5555_5555, 4'b0000);
    write_expect("R6 data A pin0 client0, client3 disabled", 3'd1, 32'h0001, 4'b0001);
    write_expect("R7 same data again", 3'd1, 32'h0001, 4'b0000);
    write_expect("R7 ctrl B no change", 3'd2, 32'h5555_5555, 4'b0000);
    write_expect("R6 data B pin0 client2", 3'd3, 32'h0001, 4'b0100);
    check("R6 line_b", 32'(line_b), 32'h0001);
    // Pin 0 drops to floating, pin 8 pulled up: change 0x0101.
    write_expect("R5 ctrl A two pins", 3'd0, 32'h0002_0000, 4'b0011);
    check("R1 pull bit 17 on pin 8", 32'(line_a), 32'h0100);

    per_load(16'h0001, 16'h0001, 16'h0000, 16'h0000);
    check("R8 periph drive seen", 32'(line_a), 32'h0101);
    @(negedge clk);
    check("R11 no notify on periph load", 32'(notify), 0);

    write_expect("R7 data to input pins", 3'd1, 32'hFFFF, 4'b0000);
    bus_read(3'd1, rd); check("R4 resolved not written", rd, 32'h0101);
    bus_read(3'd0, rd); check("R4 ctrl A readback", rd, 32'h0002_0000);

    bus_write(3'd4, 32'h0001);
    check("R9 flag set", 32'(unsup_cfg), 1);
    bus_read(3'd4, rd); check("R9 readback", rd, 32'h0001);
    bus_write(3'd4, 32'h0000);
    check("R9 flag clear", 32'(unsup_cfg), 0);
    bus_read(3'd7, rd); check("R4 unmapped reads 0", rd, 0);

    finish_run();
  end
endmodule